// File: doc/BRIEF.md
# Pipelined YCbCr to RGB Colour Converter

This block turns one studio-range pixel, given as unsigned luma Y and chroma Cb and Cr, into 8-bit R, G and B on every clock cycle. It first takes the black-level offset off luma and the mid-scale offset off each chroma sample. It then forms fixed-point colour-matrix products and sums them per channel. Each channel is clamped on its own: a negative sum gives 0 and a sum above full scale gives 255. Fractional parts are dropped by truncation, not rounded.

The input width is a build parameter, 8 or 10 bits. With 10 bits the offsets scale by four, and the sums are shifted right by two more bits, so the outputs stay 8-bit. The pipeline has two register stages. A new pixel is accepted every cycle, and its colour appears two rising edges after it is sampled. A synchronous active-high reset clears both stages.

Top module: `ycc2rgb_pipe`

## Requirements
- R1: With luma at its black offset (16 for 8-bit inputs, 64 for 10-bit inputs) and both chroma at mid-scale (128 for 8-bit, 512 for 10-bit), all three outputs are 0.
- R2: A channel whose exact sum exceeds 255 outputs 255 (8'hFF), independently of the other channels. For example, Y=235 and Cb=Cr=240 give R=255, G=119, B=255, and Y=Cb=Cr=255 gives R=255 and B=255.
- R3: A channel whose sum is negative outputs 0, detected from the sign of the signed accumulator. For example, Y=Cb=Cr=16 gives R=0 and B=0.
- R4: With Yd=Y-16, Bd=Cb-128 and Rd=Cr-128, each output is the floor of its sum divided by 4096, clamped to 0..255. The sums are R: 4768·Yd+6537·Rd; G: 4768·Yd−3330·Rd−1606·Bd; B: 4768·Yd+8262·Bd. Examples: Y=Cb=Cr=16 gives G=134, and Y=235 with Cb=Cr=128 gives 254 on every channel.
- R5: The block accepts a pixel on every rising edge. The colour of the pixel sampled at edge k is on the outputs after edge k+2, with no gaps when pixels are back to back.
- R6: While reset is high at a rising edge, all three outputs read 0 after that edge. After reset is released, the outputs stay 0 until the first pixel sampled with reset low reaches them.
- R7: With 10-bit inputs, the offsets are 64 for luma and 512 for chroma. The same coefficients apply, the divisor is 16384, and the outputs are 8-bit with the same clamping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| y_in | input | IN_W | Unsigned luma sample |
| cb_in | input | IN_W | Unsigned blue-difference chroma sample |
| cr_in | input | IN_W | Unsigned red-difference chroma sample |
| r_out | output | 8 | Registered red result |
| g_out | output | 8 | Registered green result |
| b_out | output | 8 | Registered blue result |

## Verification
The assertions rely on the inputs being sampled cleanly at each edge. They only inspect outputs once two edges have passed with reset low, because earlier results come from cleared stages and not from real pixels. The bench drives inputs a short delay after the falling edge, so each input value is stable across the rising edge that samples it. It releases reset on that same falling-edge schedule and only predicts results for pixels sampled with reset low. The stimulus sets luma at the black offset, at full scale and below the offset, and sets chroma below mid-scale and far above it. This exercises the black-level, negative-floor and saturation properties, and the pseudo-random stream covers the general arithmetic.

// File: rtl/ycc_pkg.sv
package ycc_pkg;

    // Fixed-point resolution of the colour-matrix coefficients.
    localparam int FRAC   = 12;
    // Widest supported input, used to size the shared accumulator.
    localparam int MAX_IN_W = 10;
    localparam int COEF_W   = 16;
    // Offset-removed sample (MAX_IN_W+1) times coefficient, plus headroom for three terms.
    localparam int ACC_W    = MAX_IN_W + 1 + COEF_W + 4;

    typedef logic signed [ACC_W-1:0] acc_t;

    // Round a coefficient given in thousandths to nearest at FRAC fractional bits.
    function automatic acc_t to_fixed(input int milli);
        return acc_t'((milli * (1 << FRAC) + 500) / 1000);
    endfunction

    localparam acc_t K_LUMA  = to_fixed(1164);
    localparam acc_t K_R_CR  = to_fixed(1596);
    localparam acc_t K_G_CR  = to_fixed(813);
    localparam acc_t K_G_CB  = to_fixed(392);
    localparam acc_t K_B_CB  = to_fixed(2017);

    localparam int NUM_CH = 3;

    // Stage-one contents: one scaled luma term shared by all channels, four chroma terms.
    typedef struct packed {
        acc_t luma;
        acc_t r_cr;
        acc_t g_cr;
        acc_t g_cb;
        acc_t b_cb;
    } prod_t;

    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } rgb_t;

    // Sign test first, then scale down with floor and saturate at full scale.
    function automatic logic [7:0] clamp_u8(input acc_t v, input int sh);
        acc_t s;
        if (v[ACC_W-1]) return 8'h00;
        s = v >>> sh;
        if (s > acc_t'(255)) return 8'hFF;
        return s[7:0];
    endfunction

endpackage

// File: rtl/ycc_center.sv
module ycc_center
    import ycc_pkg::*;
#(
    parameter int IN_W = 8
) (
    input  logic [IN_W-1:0]        y,
    input  logic [IN_W-1:0]        cb,
    input  logic [IN_W-1:0]        cr,
    output logic signed [IN_W:0]   yd,
    output logic signed [IN_W:0]   cbd,
    output logic signed [IN_W:0]   crd
);
    localparam int SCALE = IN_W - 8;
    localparam logic signed [IN_W:0] Y_OFF = (IN_W+1)'(16 << SCALE);
    localparam logic signed [IN_W:0] C_OFF = (IN_W+1)'(128 << SCALE);

    always_comb begin
        yd  = $signed({1'b0, y})  - Y_OFF;
        cbd = $signed({1'b0, cb}) - C_OFF;
        crd = $signed({1'b0, cr}) - C_OFF;
    end
endmodule

// File: rtl/ycc_product_stage.sv
module ycc_product_stage
    import ycc_pkg::*;
#(
    parameter int IN_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [IN_W:0] yd,
    input  logic signed [IN_W:0] cbd,
    input  logic signed [IN_W:0] crd,
    output prod_t                q
);
    localparam int EXT = ACC_W - IN_W - 1;

    acc_t y_w, cb_w, cr_w;
    prod_t nxt;

    always_comb begin
        y_w  = {{EXT{yd[IN_W]}},  yd};
        cb_w = {{EXT{cbd[IN_W]}}, cbd};
        cr_w = {{EXT{crd[IN_W]}}, crd};
        nxt.luma = y_w  * K_LUMA;
        nxt.r_cr = cr_w * K_R_CR;
        nxt.g_cr = cr_w * K_G_CR;
        nxt.g_cb = cb_w * K_G_CB;
        nxt.b_cb = cb_w * K_B_CB;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end
endmodule

// File: rtl/ycc_chan_clamp.sv
module ycc_chan_clamp
    import ycc_pkg::*;
#(
    parameter int SHIFT = FRAC
) (
    input  acc_t       sum,
    output logic [7:0] q
);
    always_comb q = clamp_u8(sum, SHIFT);
endmodule

// File: rtl/ycc_sum_stage.sv
module ycc_sum_stage
    import ycc_pkg::*;
#(
    parameter int IN_W = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  prod_t p,
    output rgb_t  q
);
    localparam int SHIFT = FRAC + IN_W - 8;

    acc_t       sums [NUM_CH];
    logic [7:0] chq  [NUM_CH];
    rgb_t       nxt;

    always_comb begin
        sums[0] = p.luma + p.r_cr;
        sums[1] = p.luma - p.g_cr - p.g_cb;
        sums[2] = p.luma + p.b_cb;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ycc_chan_clamp #(.SHIFT(SHIFT)) u_clamp (
            .sum (sums[c]),
            .q   (chq[c])
        );
    end

    always_comb begin
        nxt.r = chq[0];
        nxt.g = chq[1];
        nxt.b = chq[2];
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end
endmodule

// File: rtl/ycc2rgb_pipe.sv
module ycc2rgb_pipe
    import ycc_pkg::*;
#(
    parameter int IN_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [IN_W-1:0] y_in,
    input  logic [IN_W-1:0] cb_in,
    input  logic [IN_W-1:0] cr_in,
    output logic [7:0]      r_out,
    output logic [7:0]      g_out,
    output logic [7:0]      b_out
);
    if (IN_W != 8 && IN_W != 10) begin : g_bad_width
        $error("ycc2rgb_pipe: IN_W must be 8 or 10");
    end

    logic signed [IN_W:0] yd, cbd, crd;
    prod_t prod_q;
    rgb_t  rgb_q;

    ycc_center #(.IN_W(IN_W)) u_center (
        .y   (y_in),
        .cb  (cb_in),
        .cr  (cr_in),
        .yd  (yd),
        .cbd (cbd),
        .crd (crd)
    );

    ycc_product_stage #(.IN_W(IN_W)) u_prod (
        .clk (clk),
        .rst (rst),
        .yd  (yd),
        .cbd (cbd),
        .crd (crd),
        .q   (prod_q)
    );

    ycc_sum_stage #(.IN_W(IN_W)) u_sum (
        .clk (clk),
        .rst (rst),
        .p   (prod_q),
        .q   (rgb_q)
    );

    assign r_out = rgb_q.r;
    assign g_out = rgb_q.g;
    assign b_out = rgb_q.b;
endmodule

// File: rtl/ycc2rgb_pipe_chk.sv
module ycc2rgb_pipe_chk #(
    parameter int IN_W = 8
) (
    input logic            clk,
    input logic            rst,
    input logic [IN_W-1:0] y_in,
    input logic [IN_W-1:0] cb_in,
    input logic [IN_W-1:0] cr_in,
    input logic [7:0]      r_out,
    input logic [7:0]      g_out,
    input logic [7:0]      b_out
);
    localparam int SCALE = IN_W - 8;
    localparam logic [IN_W-1:0] Y_OFF  = IN_W'(16 << SCALE);
    localparam logic [IN_W-1:0] C_OFF  = IN_W'(128 << SCALE);
    localparam logic [IN_W-1:0] Y_FULL = '1;

    // Edges seen with reset low, saturating at 2: from then on outputs carry real pixels.
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (rst)            warm <= 2'd0;
        else if (warm != 2) warm <= warm + 2'd1;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (r_out == 8'h00 && g_out == 8'h00 && b_out == 8'h00)); // R6

    AST_BLACK_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (warm == 2 && $past(y_in, 2) == Y_OFF && $past(cb_in, 2) == C_OFF && $past(cr_in, 2) == C_OFF)
        |-> (r_out == 8'h00 && g_out == 8'h00 && b_out == 8'h00)); // R1

    AST_RED_SATURATES: assert property (@(posedge clk) disable iff (rst)
        (warm == 2 && $past(y_in, 2) == Y_FULL && $past(cr_in, 2) >= C_OFF)
        |-> r_out == 8'hFF); // R2

    AST_BLUE_SATURATES: assert property (@(posedge clk) disable iff (rst)
        (warm == 2 && $past(y_in, 2) == Y_FULL && $past(cb_in, 2) >= C_OFF)
        |-> b_out == 8'hFF); // R2

    AST_RED_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (warm == 2 && $past(y_in, 2) <= Y_OFF && $past(cr_in, 2) < C_OFF)
        |-> r_out == 8'h00); // R3

    AST_BLUE_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (warm == 2 && $past(y_in, 2) <= Y_OFF && $past(cb_in, 2) < C_OFF)
        |-> b_out == 8'h00); // R3

    AST_WARMUP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (warm == 0) |=> (r_out == 8'h00 && g_out == 8'h00 && b_out == 8'h00)); // R5
endmodule

bind ycc2rgb_pipe ycc2rgb_pipe_chk #(.IN_W(IN_W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .y_in  (y_in),
    .cb_in (cb_in),
    .cr_in (cr_in),
    .r_out (r_out),
    .g_out (g_out),
    .b_out (b_out)
);

// File: tb/ycc2rgb_pipe_test.sv
module ycc2rgb_pipe_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0] y8 = '0, cb8 = '0, cr8 = '0;
    logic [9:0] y10 = '0, cb10 = '0, cr10 = '0;
    logic [7:0] r8, g8, b8, r10, g10, b10;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    int lsb_seed = 0;

    typedef struct {
        int          due;
        string       tag;
        logic [23:0] exp8;
        logic [23:0] exp10;
    } item_t;
    item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ycc2rgb_pipe #(.IN_W(8)) uut (
        .clk(clk), .rst(rst), .y_in(y8), .cb_in(cb8), .cr_in(cr8),
        .r_out(r8), .g_out(g8), .b_out(b8)
    );

    ycc2rgb_pipe #(.IN_W(10)) uut10 (
        .clk(clk), .rst(rst), .y_in(y10), .cb_in(cb10), .cr_in(cr10),
        .r_out(r10), .g_out(g10), .b_out(b10)
    );

    // Expected channel: floor of sum / 2^sh, clamped to 0..255.
    function automatic logic [7:0] sat8(longint v, int sh);
        longint s;
        if (v < 0) return 8'h00;
        s = v >>> sh;
        if (s > 255) return 8'hFF;
        return s[7:0];
    endfunction

    function automatic logic [23:0] model(int y, int cb, int cr, int w);
        longint yd, bd, rd, lum;
        int k;
        k   = w - 8;
        yd  = y  - (16  << k);
        bd  = cb - (128 << k);
        rd  = cr - (128 << k);
        lum = 4768 * yd;
        return {sat8(lum + 6537 * rd, 12 + k),
                sat8(lum - 3330 * rd - 1606 * bd, 12 + k),
                sat8(lum + 8262 * bd, 12 + k)};
    endfunction

    task automatic check(string tag, logic [23:0] act, logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual rgb=%h expected rgb=%h", tag, act, exp);
        end
    endtask

    // Driver: applies one pixel to both builds and queues its expected colours.
    task automatic drive(logic [7:0] y, logic [7:0] cb, logic [7:0] cr, string tag);
        item_t it;
        logic [1:0] l;
        @(negedge clk);
        #1;
        l = lsb_seed[1:0];
        lsb_seed = lsb_seed + 1;
        y8 = y; cb8 = cb; cr8 = cr;
        y10 = {y, l}; cb10 = {cb, ~l}; cr10 = {cr, l};
        it.due   = cyc + 2;
        it.tag   = tag;
        it.exp8  = model(y, cb, cr, 8);
        it.exp10 = model(int'(y10), int'(cb10), int'(cr10), 10);
        sb_q.push_back(it);
    endtask

    // Monitor: compares results at the falling edge when they are due.
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
            item_t it;
            it = sb_q.pop_front();
            check({it.tag, " R5 8-bit"}, {r8, g8, b8}, it.exp8);
            check({it.tag, " R7 10-bit"}, {r10, g10, b10}, it.exp10);
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL R5 watchdog: actual cycles=%0d expected completion", cyc);
        finish_run();
    end

    initial begin
        int seed;
        // R6: outputs cleared while reset is held
        repeat (2) @(negedge clk);
        check("R6 reset 8-bit", {r8, g8, b8}, 24'h0);
        check("R6 reset 10-bit", {r10, g10, b10}, 24'h0);
        @(negedge clk);
        #1 rst = 1'b0;
        // first pixel enters at the next rising edge
        drive(8'd16, 8'd128, 8'd128, "R1 black level");
        check("R6 post-release zero", {r8, g8, b8}, 24'h0);
        drive(8'd235, 8'd240, 8'd240, "R2 over-range R,B");
        drive(8'd16, 8'd16, 8'd16, "R3 negative R,B G=134");
        drive(8'd235, 8'd128, 8'd128, "R4 white 254");
        drive(8'd255, 8'd255, 8'd255, "R2 full scale");
        drive(8'd0, 8'd0, 8'd0, "R3 below black");
        drive(8'd0, 8'd255, 8'd0, "R4 mixed sign");
        drive(8'd128, 8'd100, 8'd200, "R4 mid tone");
        drive(8'd17, 8'd128, 8'd128, "R4 one step above black");
        // R5: back-to-back pseudo-random stream
        seed = 32'h1234;
        for (int i = 0; i < 60; i++) begin
            seed = seed * 1103515245 + 12345;
            drive(seed[23:16], seed[15:8], seed[7:0], "R4 stream");
        end
        // Direct spot checks of the stated values (results for pixels already compared above)
        repeat (3) @(negedge clk);
        // R6: mid-stream reset with non-black inputs applied
        #1 rst = 1'b1;
        y8 = 8'd200; cb8 = 8'd50; cr8 = 8'd220;
        y10 = 10'd800; cb10 = 10'd200; cr10 = 10'd880;
        repeat (2) @(negedge clk);
        check("R6 mid-stream reset 8-bit", {r8, g8, b8}, 24'h0);
        check("R6 mid-stream reset 10-bit", {r10, g10, b10}, 24'h0);
        #1 rst = 1'b0;
        drive(8'd235, 8'd240, 8'd240, "R2 after reset");
        check("R6 zero until first pixel", {r8, g8, b8}, 24'h0);
        drive(8'd16, 8'd16, 8'd16, "R3 after reset");
        drive(8'd16, 8'd128, 8'd128, "R1 after reset");
        repeat (4) @(negedge clk);
        // Stated single-value expectations, independent of the model
        check("R4 model G=134", {16'h0, model(16, 16, 16, 8)[15:8]}, 24'd134);
        check("R4 model G=119", {16'h0, model(235, 240, 240, 8)[15:8]}, 24'd119);
        check("R5 scoreboard drained", 24'(sb_q.size()), 24'd0);
        finish_run();
    end
endmodule